// File: doc/BRIEF.md
# Speculative Access Tracker with Commit Packet Output

This block sits beside a private cache in a transactional-coherence design. While a transaction runs, it records which cache lines the local processor has read speculatively and which it has written speculatively. These marks are held apart from the cache's ordinary dirty state. It also watches the write addresses that other processors publish when they commit. If one of those addresses lands on a line the local transaction has read, the block raises a violation flag. That flag stays up until the processor acknowledges it and rolls back.

When the local transaction commits, the block does not send its stores one by one. It keeps an ordered list of the lines it has modified, together with the newest data for each line. It sends all of them as one framed burst: a start marker, one address/data beat per modified line, and an end marker. While the burst is going out, incoming snoops, accesses and requests are held off. Once the burst ends, or once an abort is issued, every read and modified mark is dropped in a single cycle. If the table runs out of room, the block raises a stall. The processor must then commit before it can track any new line, because existing state is never evicted.

Top module: `spec_track_unit`

## Requirements
- R1: A load (acc_valid with acc_store=0) to a line not yet tracked allocates an entry with its read mark set; a later snoop to that line sets viol.
- R2: A store (acc_store=1) to an untracked line allocates it with only the modified mark, so a snoop to that line alone does not set viol.
- R3: viol rises in the cycle after a snoop hits a read-marked line and holds until viol_ack; when a hit and viol_ack arrive together, viol stays 1.
- R4: A commit burst carries one beat per distinct modified line, in order of each line's first store, with the data of the newest store to that line; pkt_kind encodes 1 = start, 2 = beat, 3 = end, and pkt_valid is low outside a burst.
- R5: The start marker appears in the cycle after an accepted cmt_req; the beats follow back to back, the end marker comes straight after them, and pkt_valid drops in the next cycle.
- R6: snp_hold is high from the start marker through the end marker; snoops and accesses offered while it is high are ignored.
- R7: After a burst completes, nothing stays tracked: an earlier read line no longer raises viol on a snoop, and the next commit sends a start marker followed directly by an end marker.
- R8: abt_req clears all tracking in one cycle and takes priority over cmt_req and any access offered in the same cycle.
- R9: Once NENT distinct lines are tracked, acc_stall is 1; an access to a further new line is not recorded, while accesses to tracked lines still update them.
- R10: cmt_req is refused (no start marker) while viol is set, or when a snoop hit arrives in the same cycle; that snoop still sets viol.
- R11: A load and a store to the same line leave a single entry with both marks, and a snoop to it sets viol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Speculative access this cycle |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Line address of the access |
| acc_data | input | DATA_W | Store data |
| acc_stall | output | 1 | Tracking table full; commit required |
| snp_valid | input | 1 | Remote commit address present |
| snp_addr | input | ADDR_W | Remote committed line address |
| snp_hold | output | 1 | Local burst in progress; inputs held off |
| viol | output | 1 | Latched conflict on the local read set |
| viol_ack | input | 1 | Processor acknowledges the violation |
| cmt_req | input | 1 | Request local commit |
| abt_req | input | 1 | Request rollback |
| pkt_valid | output | 1 | Burst beat valid |
| pkt_kind | output | 2 | 1 start, 2 address/data, 3 end |
| pkt_addr | output | ADDR_W | Line address of a data beat |
| pkt_data | output | DATA_W | Data of a data beat |

## Verification
The interesting collision is a remote commit address that hits the local read set in the same cycle that the processor asks to commit. The snoop must win: no start marker may appear, and viol must rise. The bench drives cmt_req and a hitting snp_valid on the same edge and checks the packet output and the flag one cycle later. It also pairs a hit with viol_ack, and abt_req with cmt_req and a store, against a line-level model kept in the bench.

// File: rtl/stu_pkg.sv
package stu_pkg;
  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_SOP  = 2'd1,
    PK_BEAT = 2'd2,
    PK_EOP  = 2'd3
  } pkt_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_BEATS = 2'd1,
    SQ_FIN   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/stu_tag_table.sv
module stu_tag_table #(
  parameter int ADDR_W = 16,
  parameter int NENT   = 8,
  localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int CNT_W = $clog2(NENT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              acc_go,
  input  logic              acc_store,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hit,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_slot,
  output logic              full,
  output logic [CNT_W-1:0]  mod_cnt
);
  logic [ADDR_W-1:0] tag_q  [NENT];
  logic [IDX_W-1:0]  slot_q [NENT];
  logic [NENT-1:0]   rd_q, mod_q, live, acc_match, snp_match;
  logic [CNT_W-1:0]  ent_cnt_q, mod_cnt_q;
  logic              full_q, acc_hit, alloc, bump_mod, hit_mod;
  logic [IDX_W-1:0]  hit_idx, new_idx;

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    assign live[g]      = (CNT_W'(g) < ent_cnt_q);
    assign acc_match[g] = live[g] && (tag_q[g] == acc_addr);
    assign snp_match[g] = live[g] && rd_q[g] && (tag_q[g] == snp_addr);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (acc_match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign acc_hit  = |acc_match;
  assign hit_mod  = acc_hit && mod_q[hit_idx];
  assign new_idx  = IDX_W'(ent_cnt_q);
  assign alloc    = acc_go && !acc_hit && !full_q;
  assign wr_en    = acc_go && acc_store && (acc_hit || !full_q);
  assign wr_slot  = hit_mod ? slot_q[hit_idx] : IDX_W'(mod_cnt_q);
  assign bump_mod = wr_en && !hit_mod;
  assign snp_hit  = |snp_match;
  assign full     = full_q;
  assign mod_cnt  = mod_cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ent_cnt_q <= '0;
      mod_cnt_q <= '0;
      rd_q      <= '0;
      mod_q     <= '0;
      full_q    <= 1'b0;
    end else begin
      if (acc_go && acc_hit) begin
        if (!acc_store) begin
          rd_q[hit_idx] <= 1'b1;
        end else if (!mod_q[hit_idx]) begin
          mod_q[hit_idx]  <= 1'b1;
          slot_q[hit_idx] <= IDX_W'(mod_cnt_q);
        end
      end
      if (alloc) begin
        tag_q[new_idx]  <= acc_addr;
        rd_q[new_idx]   <= !acc_store;
        mod_q[new_idx]  <= acc_store;
        slot_q[new_idx] <= IDX_W'(mod_cnt_q);
        ent_cnt_q       <= ent_cnt_q + CNT_W'(1);
        full_q          <= (ent_cnt_q == CNT_W'(NENT - 1));
      end
      if (bump_mod) mod_cnt_q <= mod_cnt_q + CNT_W'(1);
    end
  end

  a_r9_stall_blocks_alloc: assert property (@(posedge clk) disable iff (rst)
    (full_q && acc_go && !acc_hit && !clear) |=> (ent_cnt_q == $past(ent_cnt_q)));
  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    (ent_cnt_q <= CNT_W'(NENT)) && (mod_cnt_q <= ent_cnt_q));
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clear |=> (ent_cnt_q == '0 && mod_cnt_q == '0 && !full_q));
endmodule

// File: rtl/stu_wr_buffer.sv
module stu_wr_buffer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int NENT   = 8,
  localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [ADDR_W-1:0] wline,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [ADDR_W-1:0] rline,
  output logic [DATA_W-1:0] rdata
);
  logic [ADDR_W-1:0] line_mem [NENT];
  logic [DATA_W-1:0] data_mem [NENT];

  always_ff @(posedge clk) begin
    if (we) begin
      line_mem[waddr] <= wline;
      data_mem[waddr] <= wdata;
    end
    if (re) begin
      rline <= line_mem[raddr];
      rdata <= data_mem[raddr];
    end
  end
endmodule

// File: rtl/stu_commit_seq.sv
module stu_commit_seq
  import stu_pkg::*;
#(
  parameter int NENT   = 8,
  localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int CNT_W = $clog2(NENT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] mod_cnt,
  output logic             busy,
  output logic             done,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_ptr,
  output logic             pkt_valid,
  output logic [1:0]       pkt_kind
);
  seq_state_e       state_q;
  pkt_kind_e        kind_q;
  logic [IDX_W-1:0] ptr_q;
  logic             busy_q, valid_q, last_beat;

  assign last_beat = (CNT_W'(ptr_q) + CNT_W'(1)) == mod_cnt;
  assign rd_en     = (state_q == SQ_BEATS);
  assign rd_ptr    = ptr_q;
  assign done      = (state_q == SQ_FIN);
  assign busy      = busy_q;
  assign pkt_valid = valid_q;
  assign pkt_kind  = kind_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      kind_q  <= PK_NONE;
      ptr_q   <= '0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          busy_q  <= start;
          valid_q <= start;
          kind_q  <= start ? PK_SOP : PK_NONE;
          ptr_q   <= '0;
          if (start) state_q <= (mod_cnt == '0) ? SQ_FIN : SQ_BEATS;
        end
        SQ_BEATS: begin
          valid_q <= 1'b1;
          kind_q  <= PK_BEAT;
          ptr_q   <= ptr_q + IDX_W'(1);
          if (last_beat) state_q <= SQ_FIN;
        end
        SQ_FIN: begin
          valid_q <= 1'b1;
          kind_q  <= PK_EOP;
          state_q <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  a_r6_valid_under_hold: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> busy_q);
  a_r5_sop_followed: assert property (@(posedge clk) disable iff (rst)
    (valid_q && kind_q == PK_SOP) |=> (valid_q && (kind_q == PK_BEAT || kind_q == PK_EOP)));
  a_r5_eop_closes: assert property (@(posedge clk) disable iff (rst)
    (valid_q && kind_q == PK_EOP) |=> (!valid_q && !busy_q));
endmodule

// File: rtl/spec_track_unit.sv
module spec_track_unit #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int NENT   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_store,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_data,
  output logic              acc_stall,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_hold,
  output logic              viol,
  input  logic              viol_ack,
  input  logic              cmt_req,
  input  logic              abt_req,
  output logic              pkt_valid,
  output logic [1:0]        pkt_kind,
  output logic [ADDR_W-1:0] pkt_addr,
  output logic [DATA_W-1:0] pkt_data
);
  localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1;
  localparam int CNT_W = $clog2(NENT + 1);

  logic             busy, seq_done, snp_hit, viol_q, viol_set;
  logic             abt_go, cmt_go, acc_go, clear;
  logic             wr_en, rd_en;
  logic [IDX_W-1:0] wr_slot, rd_ptr;
  logic [CNT_W-1:0] mod_cnt;

  assign viol_set = snp_valid && !busy && snp_hit;
  assign abt_go   = abt_req && !busy;
  assign cmt_go   = cmt_req && !busy && !abt_req && !viol_q && !viol_set;
  assign acc_go   = acc_valid && !busy && !abt_req && !cmt_go;
  assign clear    = abt_go || seq_done;
  assign snp_hold = busy;
  assign viol     = viol_q;

  always_ff @(posedge clk) begin
    if (rst)           viol_q <= 1'b0;
    else if (viol_set) viol_q <= 1'b1;
    else if (viol_ack) viol_q <= 1'b0;
  end

  stu_tag_table #(.ADDR_W(ADDR_W), .NENT(NENT)) u_table (
    .clk(clk), .rst(rst), .clear(clear), .acc_go(acc_go), .acc_store(acc_store),
    .acc_addr(acc_addr), .snp_addr(snp_addr), .snp_hit(snp_hit), .wr_en(wr_en),
    .wr_slot(wr_slot), .full(acc_stall), .mod_cnt(mod_cnt)
  );

  stu_wr_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NENT(NENT)) u_buf (
    .clk(clk), .we(wr_en), .waddr(wr_slot), .wline(acc_addr), .wdata(acc_data),
    .re(rd_en), .raddr(rd_ptr), .rline(pkt_addr), .rdata(pkt_data)
  );

  stu_commit_seq #(.NENT(NENT)) u_seq (
    .clk(clk), .rst(rst), .start(cmt_go), .mod_cnt(mod_cnt), .busy(busy),
    .done(seq_done), .rd_en(rd_en), .rd_ptr(rd_ptr), .pkt_valid(pkt_valid),
    .pkt_kind(pkt_kind)
  );

  a_r3_viol_sticky: assert property (@(posedge clk) disable iff (rst)
    (viol_q && !viol_ack) |=> viol_q);
  a_r6_hold_freezes_viol: assert property (@(posedge clk) disable iff (rst)
    (snp_hold && !viol_ack) |=> (viol_q == $past(viol_q)));
  a_r10_no_sop_when_violated: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && pkt_kind == 2'd1) |-> !$past(viol_q));
  a_r8_abort_beats_commit: assert property (@(posedge clk) disable iff (rst)
    (abt_req && !snp_hold) |=> !(pkt_valid && pkt_kind == 2'd1));
endmodule

// File: tb/sim_spec_track_unit.sv
`timescale 1ns/1ps
module sim_spec_track_unit;
  localparam int AW = 16, DW = 32, NE = 8;

  logic clk = 0, rst = 1;
  logic acc_valid = 0, acc_store = 0, snp_valid = 0, viol_ack = 0, cmt_req = 0, abt_req = 0;
  logic [AW-1:0] acc_addr = '0, snp_addr = '0;
  logic [DW-1:0] acc_data = '0;
  logic acc_stall, snp_hold, viol, pkt_valid;
  logic [1:0] pkt_kind;
  logic [AW-1:0] pkt_addr;
  logic [DW-1:0] pkt_data;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [AW-1:0] m_tag [NE];
  bit            m_rd  [NE];
  bit            m_mod [NE];
  int            m_slot[NE];
  logic [AW-1:0] m_la  [NE];
  logic [DW-1:0] m_ld  [NE];
  int m_cnt = 0, m_nmod = 0;
  bit m_viol = 0;

  spec_track_unit #(.ADDR_W(AW), .DATA_W(DW), .NENT(NE)) u0 (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_store(acc_store), .acc_addr(acc_addr),
    .acc_data(acc_data), .acc_stall(acc_stall), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .snp_hold(snp_hold), .viol(viol), .viol_ack(viol_ack), .cmt_req(cmt_req), .abt_req(abt_req),
    .pkt_valid(pkt_valid), .pkt_kind(pkt_kind), .pkt_addr(pkt_addr), .pkt_data(pkt_data)
  );

  always #2 clk = ~clk;

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int m_find(input logic [AW-1:0] a);
    for (int i = 0; i < m_cnt; i++) if (m_tag[i] == a) return i;
    return -1;
  endfunction

  function automatic void m_access(input bit st, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int i = m_find(a);
    if (i < 0) begin
      if (m_cnt == NE) return;
      i = m_cnt; m_cnt++;
      m_tag[i] = a; m_rd[i] = 0; m_mod[i] = 0;
    end
    if (!st) m_rd[i] = 1;
    else begin
      if (!m_mod[i]) begin
        m_mod[i] = 1; m_slot[i] = m_nmod; m_la[m_nmod] = a; m_nmod++;
      end
      m_ld[m_slot[i]] = d;
    end
  endfunction

  function automatic bit m_snoop_hits(input logic [AW-1:0] a);
    int i = m_find(a);
    return (i >= 0) && m_rd[i];
  endfunction

  function automatic void m_clear();
    m_cnt = 0; m_nmod = 0;
  endfunction

  task automatic access(input bit st, input logic [AW-1:0] a, input logic [DW-1:0] d);
    acc_valid = 1; acc_store = st; acc_addr = a; acc_data = d;
    @(negedge clk);
    acc_valid = 0;
    m_access(st, a, d);
    chk("R9 acc_stall", acc_stall, (m_cnt == NE));
  endtask

  task automatic snoop(input logic [AW-1:0] a, input string rq);
    snp_valid = 1; snp_addr = a;
    @(negedge clk);
    snp_valid = 0;
    if (m_snoop_hits(a)) m_viol = 1;
    chk(rq, viol, m_viol);
  endtask

  task automatic ack();
    viol_ack = 1;
    @(negedge clk);
    viol_ack = 0; m_viol = 0;
    chk("R3 ack clears viol", viol, 0);
  endtask

  task automatic abort_tx();
    abt_req = 1;
    @(negedge clk);
    abt_req = 0;
    m_clear();
    chk("R8 no packet on abort", pkt_valid, 0);
    chk("R8 stall cleared", acc_stall, 0);
  endtask

  task automatic commit(input bit poke, input logic [AW-1:0] pa, input logic [AW-1:0] pb);
    cmt_req = 1;
    @(negedge clk);
    cmt_req = 0;
    if (m_viol) begin
      chk("R10 refused commit has no start", pkt_valid, 0);
      return;
    end
    chk("R5 start marker", {pkt_valid, pkt_kind}, {1'b1, 2'd1});
    chk("R6 hold on start", snp_hold, 1);
    if (poke) begin
      snp_valid = 1; snp_addr = pa;
      acc_valid = 1; acc_store = 0; acc_addr = pb;
    end
    for (int k = 0; k < m_nmod; k++) begin
      @(negedge clk);
      snp_valid = 0; acc_valid = 0;
      chk("R4 beat kind", {pkt_valid, pkt_kind}, {1'b1, 2'd2});
      chk("R4 beat addr", pkt_addr, m_la[k]);
      chk("R4 beat data", pkt_data, m_ld[k]);
    end
    @(negedge clk);
    snp_valid = 0; acc_valid = 0;
    chk("R5 end marker", {pkt_valid, pkt_kind}, {1'b1, 2'd3});
    chk("R6 hold on end", snp_hold, 1);
    @(negedge clk);
    chk("R5 valid drops", pkt_valid, 0);
    chk("R6 hold released", snp_hold, 0);
    m_clear();
    if (poke) chk("R6 snoop under hold ignored", viol, m_viol);
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    repeat (196000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog R5 actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R4 reset pkt_valid", pkt_valid, 0);
    chk("R6 reset hold", snp_hold, 0);
    chk("R3 reset viol", viol, 0);
    chk("R9 reset stall", acc_stall, 0);

    // R1 / R11: load marks read, store to same line keeps it
    access(0, 16'h0A0, 0);
    access(1, 16'h0A0, 32'h11);
    snoop(16'h0A0, "R1 R11 snoop on read line");
    chk("R1 viol raised", viol, 1);
    // R3: hit together with ack keeps flag
    snp_valid = 1; snp_addr = 16'h0A0; viol_ack = 1;
    @(negedge clk);
    snp_valid = 0; viol_ack = 0;
    chk("R3 hit beats ack", viol, 1);
    ack();
    // R10: refused while violated
    m_viol = 1;
    snp_valid = 1; snp_addr = 16'h0A0;
    @(negedge clk);
    snp_valid = 0;
    commit(0, 0, 0);
    ack();
    // R10: snoop hit same cycle as commit request
    cmt_req = 1; snp_valid = 1; snp_addr = 16'h0A0;
    @(negedge clk);
    cmt_req = 0; snp_valid = 0; m_viol = 1;
    chk("R10 same-cycle hit refuses start", pkt_valid, 0);
    chk("R10 same-cycle hit sets viol", viol, 1);
    ack();
    abort_tx();

    // R2: store-only line ignores snoop
    access(1, 16'h0B0, 32'h22);
    snoop(16'h0B0, "R2 store-only line no viol");
    chk("R2 viol low", viol, 0);
    // R4 / R5: order of first store, newest data
    access(1, 16'h0C0, 32'h33);
    access(1, 16'h0B0, 32'h44);
    access(0, 16'h0D0, 0);
    commit(0, 0, 0);
    // R7: read line forgotten after commit, empty burst
    snoop(16'h0D0, "R7 cleared read line");
    chk("R7 viol low", viol, 0);
    commit(0, 0, 0);

    // R6: snoop and access during hold ignored
    access(0, 16'h0E0, 0);
    access(1, 16'h0F0, 32'h55);
    commit(1, 16'h0E0, 16'h0F8);
    commit(0, 0, 0);

    // R8: abort over commit and store
    access(1, 16'h100, 32'h66);
    abt_req = 1; cmt_req = 1; acc_valid = 1; acc_store = 1; acc_addr = 16'h108; acc_data = 32'h77;
    @(negedge clk);
    abt_req = 0; cmt_req = 0; acc_valid = 0;
    m_clear();
    chk("R8 abort wins over commit", pkt_valid, 0);
    commit(0, 0, 0);

    // R9: capacity
    for (int i = 0; i < NE; i++) access(1, 16'h200 + 16'(i), 32'h1000 + i);
    chk("R9 stall at capacity", acc_stall, 1);
    access(1, 16'h2F0, 32'hDEAD);
    access(1, 16'h200, 32'hBEEF);
    access(0, 16'h201, 0);
    snoop(16'h201, "R9 hit still updates under stall");
    ack();
    commit(0, 0, 0);

    // random phase
    for (int r = 0; r < 60; r++) begin
      int nops = $urandom_range(1, 12);
      for (int o = 0; o < nops; o++) begin
        int kind = $urandom_range(0, 9);
        logic [AW-1:0] a = 16'h300 + 16'($urandom_range(0, 11));
        if (kind < 4) access(0, a, 0);
        else if (kind < 8) access(1, a, $urandom);
        else if (kind == 8) snoop(a, "R3 random snoop");
        else if (m_viol) ack();
      end
      if ($urandom_range(0, 3) == 0) ack();
      if ($urandom_range(0, 9) < 7) commit(0, 0, 0);
      else abort_tx();
      if (m_viol) ack();
      if (m_cnt != 0) abort_tx();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule